// File: doc/BRIEF.md
# Host Parallel Bus Byte Exchange Port

This block sits beside a small 4-bit microcontroller core and lets an external host move bytes to and from that core over a strobed 8-bit parallel bus. The host owns three active-low control lines (chip select, read strobe, write strobe) and a byte-wide data path. The pad's tristate buffer lives outside the block: the block takes the incoming byte on `bus_in`, offers its outgoing byte on `bus_out`, and raises `bus_oe` whenever the pad must drive.

A single 8-bit transfer register serves both directions. A host write fills it; the core reads it back as two nibbles. The core can also load it from two nibbles, after which a host read returns it. A one-bit handshake flag, set by the core to request a transfer, is cleared by any completed host write. A host that has just read therefore follows up with a throw-away write, purely to drop the flag and tell the core the byte was taken.

The port runs on the undivided core input clock (200 ns period). The control lines and the incoming byte pass through the same two-flop synchroniser, so a strobe two clock cycles wide is enough.

Top module: `hbs_host_port`

## Requirements
- R1: `host_ctl` carries the host's control lines, all active low: bit 1 is the read strobe, bit 2 is chip select, bit 3 is the write strobe.
- R2: While chip select and write are both low, the byte on `bus_in` is taken. When that window closes, it lands in the transfer register. The core then sees bits 7:4 on `core_hi_q` and bits 3:0 on `core_lo_q`.
- R3: While chip select and read are both low, `bus_oe` is 1 and `bus_out` carries the transfer register.
- R4: Outside a read window, `bus_oe` is 0. A write strobe while chip select is high changes neither the register nor the flag.
- R5: Every completed host write, including a dummy write after a read, clears the handshake flag `flag_q`.
- R6: `flag_set` sets the flag and `flag_clr` clears it. When both are high in one cycle, set wins.
- R7: A host write that completes in the same cycle as `flag_set` leaves the flag at 0.
- R8: `core_load` writes `{core_hi, core_lo}` into the register. A host write that completes in the same cycle takes priority over it.
- R9: Reset, synchronous and active low on `rst_n`, clears the register and the flag and drops `bus_oe`.
- R10: A strobe window held for two clock cycles is accepted in full, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (undivided core input clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| host_ctl | input | 3 | Host control lines [3:1]: write, chip select, read (active low) |
| bus_in | input | 8 | Byte arriving from the host data pad |
| bus_out | output | 8 | Byte offered to the host data pad |
| bus_oe | output | 1 | Pad drive enable during host reads |
| core_load | input | 1 | Core loads the transfer register |
| core_hi | input | 4 | Upper nibble for a core load |
| core_lo | input | 4 | Lower nibble for a core load |
| core_hi_q | output | 4 | Upper nibble of the transfer register |
| core_lo_q | output | 4 | Lower nibble of the transfer register |
| flag_set | input | 1 | Core sets the handshake flag |
| flag_clr | input | 1 | Core clears the handshake flag |
| flag_q | output | 1 | Handshake flag value |

## Verification
The assertions assume a well-formed host. The byte on `bus_in` stays stable for as long as the write strobe is low, and each strobe is held for at least two clock cycles, so the data pipeline lines up with the synchronised window. The stimulus meets both assumptions by drawing strobe widths from 2 to 5 cycles and changing the byte only while the strobes are high. Between strobes it puts random junk on `bus_in`, and it adds write strobes with chip select high that must leave the port untouched. It also drives core loads and flag pulses into the exact cycle in which a host write completes, to exercise the priority rules.

// File: rtl/hbs_pkg.sv
// Package: shared widths and host control pin positions for the host port.
// Assumes: control lines are active low; pin positions are fixed by board wiring.
package hbs_pkg;
    localparam int DATA_W      = 8;
    localparam int NIB_W       = DATA_W / 2;
    localparam int SYNC_STAGES = 2;
    localparam int PIN_RD      = 1;
    localparam int PIN_CS      = 2;
    localparam int PIN_WR      = 3;

    // Synchronised control lines, still active low.
    typedef struct packed {
        logic wr_n;
        logic cs_n;
        logic rd_n;
    } ctl_t;
endpackage

// File: rtl/hbs_sync.sv
// Module: multi-flop synchroniser chain for a vector of inputs.
// Assumes: each bit is independent; RST_VAL is the idle level of the signal.
module hbs_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else begin
                    if (s == 0) chain[s] <= d;
                    else        chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbs_decode.sv
// Module: turns synchronised host control lines into read/write window and
// write-completion events.
// Assumes: inputs are already synchronised; a write completes when the
// combined chip-select-and-write window closes.
module hbs_decode
    import hbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    output logic rd_win,
    output logic wr_win,
    output logic wr_done
);
    logic wr_win_q;

    assign rd_win  = !ctl.cs_n && !ctl.rd_n;
    assign wr_win  = !ctl.cs_n && !ctl.wr_n;
    assign wr_done = wr_win_q && !wr_win;

    // Purpose: remember last cycle's write window to find its end.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_win_q <= 1'b0;
        else        wr_win_q <= wr_win;
    end

    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(wr_win)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done); // R5
endmodule

// File: rtl/hbs_xfer_reg.sv
// Module: the shared transfer register with host staging and core load.
// Assumes: host data is aligned with the synchronised write window.
module hbs_xfer_reg
    import hbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_win,
    input  logic              wr_done,
    input  logic [DATA_W-1:0] host_byte,
    input  logic              core_load,
    input  logic [NIB_W-1:0]  core_hi,
    input  logic [NIB_W-1:0]  core_lo,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] stage_q;

    // Purpose: track the host byte while the write window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= '0;
        else if (wr_win) stage_q <= host_byte;
    end

    // Purpose: commit host data (priority) or a core load.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (wr_done)   q <= stage_q;
        else if (core_load) q <= {core_hi, core_lo};
    end

    AST_HOST_BEATS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> q == $past(stage_q)); // R8
    AST_CORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_load && !wr_done) |=> q == {$past(core_hi), $past(core_lo)}); // R8
    AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_load && !wr_done) |=> $stable(q)); // R4
endmodule

// File: rtl/hbs_flag.sv
// Module: handshake flag set by the core, cleared by core or host write.
// Assumes: host clear outranks core set, which outranks core clear.
module hbs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic host_clr,
    input  logic core_set,
    input  logic core_clr,
    output logic q
);
    // Purpose: apply flag updates in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= 1'b0;
        else if (host_clr) q <= 1'b0;
        else if (core_set) q <= 1'b1;
        else if (core_clr) q <= 1'b0;
    end

    AST_HOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> !q); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_set && !host_clr) |=> q); // R6
endmodule

// File: rtl/hbs_host_port.sv
// Module: top of the host parallel-bus slave port.
// Assumes: host strobes are at least two clock cycles wide; the pad tristate
// buffer is outside this block and driven from bus_out/bus_oe.
module hbs_host_port
    import hbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:1]        host_ctl,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic              core_load,
    input  logic [NIB_W-1:0]  core_hi,
    input  logic [NIB_W-1:0]  core_lo,
    output logic [NIB_W-1:0]  core_hi_q,
    output logic [NIB_W-1:0]  core_lo_q,
    input  logic              flag_set,
    input  logic              flag_clr,
    output logic              flag_q
);
    ctl_t              ctl_raw, ctl_s;
    logic [DATA_W-1:0] byte_s;
    logic [DATA_W-1:0] xfer_q;
    logic              rd_win, wr_win, wr_done;

    assign ctl_raw.wr_n = host_ctl[PIN_WR];
    assign ctl_raw.cs_n = host_ctl[PIN_CS];
    assign ctl_raw.rd_n = host_ctl[PIN_RD];

    hbs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    hbs_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(byte_s)
    );

    hbs_decode u_decode (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_s),
        .rd_win(rd_win), .wr_win(wr_win), .wr_done(wr_done)
    );

    hbs_xfer_reg u_xfer (
        .clk(clk), .rst_n(rst_n), .wr_win(wr_win), .wr_done(wr_done),
        .host_byte(byte_s), .core_load(core_load),
        .core_hi(core_hi), .core_lo(core_lo), .q(xfer_q)
    );

    hbs_flag u_flag (
        .clk(clk), .rst_n(rst_n), .host_clr(wr_done),
        .core_set(flag_set), .core_clr(flag_clr), .q(flag_q)
    );

    assign bus_oe    = rd_win;
    assign bus_out   = xfer_q;
    assign core_hi_q = xfer_q[DATA_W-1:NIB_W];
    assign core_lo_q = xfer_q[NIB_W-1:0];

    AST_OE_NOT_DURING_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out) || $past(wr_done) || $past(core_load)); // R3
endmodule

// File: tb/tb_hbs_host_port.sv
module tb_hbs_host_port;
    localparam int CLK_PERIOD = 200;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:1] host_ctl;
    logic [7:0] bus_in, bus_out;
    logic       bus_oe, core_load, flag_set, flag_clr, flag_q;
    logic [3:0] core_hi, core_lo, core_hi_q, core_lo_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_reg;
    logic       exp_flag;

    hbs_host_port dut (
        .clk(clk), .rst_n(rst_n), .host_ctl(host_ctl), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .core_load(core_load),
        .core_hi(core_hi), .core_lo(core_lo), .core_hi_q(core_hi_q),
        .core_lo_q(core_lo_q), .flag_set(flag_set), .flag_clr(flag_clr),
        .flag_q(flag_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Control line encoding per R1: {wr_n, cs_n, rd_n} on bits [3:1].
    function automatic logic [3:1] ctl_word(input logic wr_n, input logic cs_n, input logic rd_n);
        return {wr_n, cs_n, rd_n};
    endfunction

    function automatic logic next_flag(input logic cur, input logic hclr,
                                       input logic s, input logic c);
        if (hclr) return 1'b0;
        if (s)    return 1'b1;
        if (c)    return 1'b0;
        return cur;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(req, {core_hi_q, core_lo_q}, exp_reg);
        check(req, flag_q, exp_flag);
    endtask

    // Host write; collide=1 places core_load and flag_set on the completion cycle.
    task automatic host_write(input logic [7:0] b, input int w, input logic collide);
        @(negedge clk);
        bus_in = b; host_ctl = ctl_word(1'b0, 1'b0, 1'b1);
        repeat (w) @(posedge clk);
        @(negedge clk);
        host_ctl = ctl_word(1'b1, 1'b1, 1'b1); bus_in = 8'($urandom);
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        if (collide) begin
            core_load = 1'b1; core_hi = ~b[7:4]; core_lo = ~b[3:0]; flag_set = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        core_load = 1'b0; flag_set = 1'b0;
        exp_reg = b; exp_flag = 1'b0;
        check_state(collide ? "R7/R8 host wins" : "R2/R5 write");
    endtask

    task automatic host_read(input int w);
        @(negedge clk);
        host_ctl = ctl_word(1'b1, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 oe", bus_oe, 1'b1);
        check("R3 data", bus_out, exp_reg);
        repeat (w - 2) begin @(posedge clk); @(negedge clk); end
        host_ctl = ctl_word(1'b1, 1'b1, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4 released", bus_oe, 1'b0);
    endtask

    task automatic core_step(input logic ld, input logic [7:0] v, input logic s, input logic c);
        @(negedge clk);
        core_load = ld; core_hi = v[7:4]; core_lo = v[3:0]; flag_set = s; flag_clr = c;
        @(posedge clk); @(negedge clk);
        core_load = 1'b0; flag_set = 1'b0; flag_clr = 1'b0;
        if (ld) exp_reg = v;
        exp_flag = next_flag(exp_flag, 1'b0, s, c);
        check_state("R6/R8 core");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; host_ctl = 3'b111; bus_in = 8'hA5;
        core_load = 1'b1; core_hi = 4'hF; core_lo = 4'hF; flag_set = 1'b1; flag_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_reg = 8'h00; exp_flag = 1'b0;
        check_state("R9 reset");
        check("R9 oe", bus_oe, 1'b0);
        core_load = 1'b0; flag_set = 1'b0;
        rst_n = 1'b1;

        // Directed corners
        core_step(1'b0, 8'h00, 1'b1, 1'b1);      // R6 set beats clear
        host_write(8'h48, 2, 1'b0);              // R10 two-cycle write, R5 clears flag
        host_read(2);                            // R10 two-cycle read
        core_step(1'b1, 8'h3C, 1'b1, 1'b0);
        host_read(3);
        host_write(8'hE7, 2, 1'b1);              // R7, R8 collisions
        core_step(1'b0, 8'h00, 1'b1, 1'b0);
        // R4: write strobe with chip select high is ignored
        @(negedge clk);
        bus_in = 8'h11; host_ctl = ctl_word(1'b0, 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        host_ctl = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_state("R4 cs high write ignored");
        check("R1 read pin alone", bus_oe, 1'b0);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(0, 4);
            int w  = $urandom_range(2, 5);
            case (op)
                0: host_write(8'($urandom), w, 1'($urandom_range(0, 1)));
                1: begin host_read(w); host_write(8'($urandom), 2, 1'b0); end
                2: host_read(w);
                default: core_step(1'($urandom), 8'($urandom),
                                   1'($urandom), 1'($urandom));
            endcase
            repeat ($urandom_range(0, 3)) @(posedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule